// File: doc/BRIEF.md
# Acknowledged Packet Exchange Sequencer

This block is the control engine for one side of an acknowledged radio link. After the host loads a packet and raises a single go request, the sequencer runs the whole exchange without further help. It powers the oscillator and synthesizer and waits until they report lock. It then sends the buffered packet and turns the radio around to listen. The exchange closes when a good acknowledgement arrives or when a programmable wait runs out.

In receive mode the same engine listens until a packet with a good CRC arrives. It signals the host, then turns around and transmits a short acknowledgement frame. That frame carries the 16-bit CRC of the packet just taken in.

The radio datapath and the CRC arithmetic sit outside this block. The block only issues enables and strobes, and it reacts to the packet-complete and CRC-good indications. It steers the data buffer enables so that acknowledgement traffic never touches the data buffers. A configurable end state chooses what happens after each exchange: the block either drops back to idle with the radio off, or keeps listening in receive.

Top module: `ack_xact_seq`

## Requirements
- R1: A one-cycle `go_set` pulse sets `go_pending` from the next cycle. The bit clears on the clock edge at which the sequencer leaves idle. A `go_set` on that same edge keeps it set, so the request is queued.
- R2: When a sequence starts, `pwr_en` and `busy` rise. Neither `tx_en` nor `rx_en` asserts until `synth_ready` has been seen high.
- R3: In transmit mode (`mode_rx`=0, sampled at start), once the synthesizer is ready the block asserts `tx_en` and `buf_rd_en`. `tx_start` is high for exactly the first cycle of that state. On `pkt_done` the block drops `tx_en` and raises `rx_en` to wait for an acknowledgement.
- R4: While waiting for an acknowledgement, `pkt_done` with `crc_ok`=1 ends the exchange and leaves `no_ack`=0.
- R5: The acknowledgement wait lasts at most `timeout_cycles` cycles, counted from its first cycle; a value of 0 acts as 1. When the wait runs out, the exchange ends and `no_ack` becomes 1. An acknowledgement that arrives in the last allowed cycle takes priority over the timeout.
- R6: In receive mode (`mode_rx`=1), a `pkt_done` with `crc_ok`=1 moves the block from listening to sending an acknowledgement. In the first cycle of the send, `tx_en`, `send_ack`, `tx_start` and a one-cycle `rx_irq` are all high. The next `pkt_done` ends the exchange.
- R7: A `pkt_done` with `crc_ok`=0 is ignored. While listening, the block keeps listening, gives no `rx_irq`, and leaves `ack_crc` unchanged. While waiting for an acknowledgement, such a packet is not taken as one.
- R8: `ack_crc` equals the `rx_crc` value that came with the most recent good received packet, and it holds that value until the next one arrives. Its reset value is 0.
- R9: The data buffers are not touched by acknowledgement traffic. `buf_wr_en` is high only while listening for a data packet, and `buf_rd_en` is high only while sending the data packet. Both are low while an acknowledgement is sent or awaited.
- R10: Each exchange ends with `done_irq` high for exactly one cycle. On the next edge the block goes to idle with all enables low if `end_rx`=0, or goes back to listening if `end_rx`=1.
- R11: `no_ack` keeps its value until the next sequence start, and that start clears it.
- R12: `tx_en` and `rx_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_set | input | 1 | Host pulse that requests a sequence |
| mode_rx | input | 1 | 0 = transmit exchange, 1 = receive exchange; sampled at start |
| end_rx | input | 1 | End state: 0 = idle, 1 = return to listening |
| timeout_cycles | input | TMO_W | Acknowledgement wait limit in cycles (0 acts as 1) |
| synth_ready | input | 1 | Oscillator and synthesizer locked |
| pkt_done | input | 1 | Radio finished sending or receiving a packet |
| crc_ok | input | 1 | Received packet has a valid CRC (qualified by pkt_done) |
| rx_crc | input | CRC_W | CRC field of the received packet |
| go_pending | output | 1 | Self-clearing go bit |
| busy | output | 1 | Sequencer is not idle |
| pwr_en | output | 1 | Oscillator and synthesizer enable |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| tx_start | output | 1 | One-cycle strobe that launches a transmission |
| send_ack | output | 1 | Transmission is an acknowledgement frame built from ack_crc |
| buf_rd_en | output | 1 | Transmit data buffer may be read |
| buf_wr_en | output | 1 | Receive data buffer may be written |
| ack_crc | output | CRC_W | CRC echoed in the acknowledgement frame |
| rx_irq | output | 1 | One-cycle pulse: good packet received |
| done_irq | output | 1 | One-cycle pulse: exchange finished |
| no_ack | output | 1 | Last transmit exchange timed out |

## Verification
Every output comes from a register, so each response is due exactly one edge after the input that causes it. A `go_set` shows in `go_pending` after one edge and in `busy` after two. `synth_ready` moves the radio enables after one edge. A `pkt_done` changes `tx_en`/`rx_en`, `ack_crc` and `rx_irq` on the edge that samples it. `done_irq` is followed by the end-state choice one edge later. The bench drives inputs at falling edges and advances a behavioural model on each rising edge. It compares every output at the next falling edge, so each expectation is checked in the cycle it falls due. The timeout boundary is probed with an acknowledgement placed in the last allowed cycle and with a limit of zero.

// File: rtl/ack_seq_pkg.sv
package ack_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WARM = 3'd1,
    ST_TXD  = 3'd2,
    ST_ACKW = 3'd3,
    ST_RXW  = 3'd4,
    ST_TXA  = 3'd5,
    ST_END  = 3'd6
  } seq_state_t;

  // wait limit reached: cycles spent so far (cnt+1) meet the limit, 0 acts as 1
  function automatic logic tmo_hit(input logic [31:0] cnt, input logic [31:0] lim);
    logic [32:0] used;
    logic [32:0] eff;
    used = {1'b0, cnt} + 33'd1;
    eff  = (lim == 32'd0) ? 33'd1 : {1'b0, lim};
    return used >= eff;
  endfunction

  function automatic logic st_is_tx(input seq_state_t s);
    return (s == ST_TXD) || (s == ST_TXA);
  endfunction

  function automatic logic st_is_rx(input seq_state_t s);
    return (s == ST_ACKW) || (s == ST_RXW);
  endfunction

endpackage

// File: rtl/ack_seq_timer.sv
module ack_seq_timer
  import ack_seq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && tmo_hit(32'(cnt_q), 32'(limit));

  // R5
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> (!run || cnt_q != '0));

endmodule

// File: rtl/ack_seq_crc_hold.sv
module ack_seq_crc_hold #(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CRC_W-1:0] crc_in,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (cap) crc_q <= crc_in;
  end

  // R8
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(crc_q));

  // R8
  crc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (crc_q == $past(crc_in)));

endmodule

// File: rtl/ack_seq_fsm.sv
module ack_seq_fsm
  import ack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_set,
  input  logic       mode_rx,
  input  logic       end_rx,
  input  logic       synth_ready,
  input  logic       pkt_done,
  input  logic       crc_ok,
  input  logic       tmo_expire,
  output seq_state_t state,
  output logic       go_q,
  output logic       no_ack_q,
  output logic       tx_start_q,
  output logic       rx_irq_q,
  output logic       crc_cap,
  output logic       timer_run
);
  seq_state_t nxt;
  logic       mode_q;
  logic       start;
  logic       good_pkt;
  logic       ack_seen;
  logic       gave_up;

  assign start     = (state == ST_IDLE) && go_q;
  assign good_pkt  = pkt_done && crc_ok;
  assign ack_seen  = (state == ST_ACKW) && good_pkt;
  assign gave_up   = (state == ST_ACKW) && !good_pkt && tmo_expire;
  assign crc_cap   = (state == ST_RXW) && good_pkt;
  assign timer_run = (state == ST_ACKW);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (go_q) nxt = ST_WARM;
      ST_WARM: if (synth_ready) nxt = mode_q ? ST_RXW : ST_TXD;
      ST_TXD:  if (pkt_done) nxt = ST_ACKW;
      ST_ACKW: if (ack_seen || gave_up) nxt = ST_END;
      ST_RXW:  if (good_pkt) nxt = ST_TXA;
      ST_TXA:  if (pkt_done) nxt = ST_END;
      ST_END:  nxt = end_rx ? ST_RXW : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      go_q       <= 1'b0;
      mode_q     <= 1'b0;
      no_ack_q   <= 1'b0;
      tx_start_q <= 1'b0;
      rx_irq_q   <= 1'b0;
    end else begin
      state      <= nxt;
      go_q       <= go_set | (go_q & !start);
      if (start) mode_q <= mode_rx;
      if (start) no_ack_q <= 1'b0;
      else if (gave_up) no_ack_q <= 1'b1;
      tx_start_q <= st_is_tx(nxt) && (nxt != state);
      rx_irq_q   <= crc_cap;
    end
  end

  // R1
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && go_q && !go_set) |=> !go_q);

  // R2
  warm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WARM && !synth_ready) |=> (state == ST_WARM));

  // R5
  noack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_ack_q) |-> ($past(state) == ST_ACKW));

  // R11
  noack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ack_q && state != ST_IDLE) |=> no_ack_q);

  // R7
  bad_crc_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RXW && pkt_done && !crc_ok) |=> (state == ST_RXW && !rx_irq_q));

endmodule

// File: rtl/ack_xact_seq.sv
module ack_xact_seq
  import ack_seq_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_set,
  input  logic             mode_rx,
  input  logic             end_rx,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic             synth_ready,
  input  logic             pkt_done,
  input  logic             crc_ok,
  input  logic [CRC_W-1:0] rx_crc,
  output logic             go_pending,
  output logic             busy,
  output logic             pwr_en,
  output logic             tx_en,
  output logic             rx_en,
  output logic             tx_start,
  output logic             send_ack,
  output logic             buf_rd_en,
  output logic             buf_wr_en,
  output logic [CRC_W-1:0] ack_crc,
  output logic             rx_irq,
  output logic             done_irq,
  output logic             no_ack
);
  seq_state_t state;
  logic       tmo_expire;
  logic       crc_cap;
  logic       timer_run;

  ack_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_set      (go_set),
    .mode_rx     (mode_rx),
    .end_rx      (end_rx),
    .synth_ready (synth_ready),
    .pkt_done    (pkt_done),
    .crc_ok      (crc_ok),
    .tmo_expire  (tmo_expire),
    .state       (state),
    .go_q        (go_pending),
    .no_ack_q    (no_ack),
    .tx_start_q  (tx_start),
    .rx_irq_q    (rx_irq),
    .crc_cap     (crc_cap),
    .timer_run   (timer_run)
  );

  ack_seq_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .limit  (timeout_cycles),
    .expire (tmo_expire)
  );

  ack_seq_crc_hold #(.CRC_W(CRC_W)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (crc_cap),
    .crc_in (rx_crc),
    .crc_q  (ack_crc)
  );

  assign busy      = (state != ST_IDLE);
  assign pwr_en    = (state != ST_IDLE);
  assign tx_en     = st_is_tx(state);
  assign rx_en     = st_is_rx(state);
  assign send_ack  = (state == ST_TXA);
  assign buf_rd_en = (state == ST_TXD);
  assign buf_wr_en = (state == ST_RXW);
  assign done_irq  = (state == ST_END);

  // R12
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en));

  // R9
  buf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ack || timer_run) |-> !(buf_rd_en || buf_wr_en));

  // R5
  expire_react_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expire |=> (done_irq && !rx_en));

  // R6
  rxirq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (send_ack && tx_start));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

endmodule

// File: tb/sim_ack_xact_seq.sv
module sim_ack_xact_seq;
  localparam int TMO_W = 16;
  localparam int CRC_W = 16;
  localparam int P_IDLE = 0, P_WARM = 1, P_TXD = 2, P_ACKW = 3,
                 P_RXW = 4, P_TXA = 5, P_END = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_set = 1'b0, mode_rx = 1'b0, end_rx = 1'b0;
  logic [TMO_W-1:0] timeout_cycles = 16'd8;
  logic synth_ready = 1'b0, pkt_done = 1'b0, crc_ok = 1'b0;
  logic [CRC_W-1:0] rx_crc = '0;
  logic go_pending, busy, pwr_en, tx_en, rx_en, tx_start, send_ack;
  logic buf_rd_en, buf_wr_en, rx_irq, done_irq, no_ack;
  logic [CRC_W-1:0] ack_crc;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ack_xact_seq #(.TMO_W(TMO_W), .CRC_W(CRC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .mode_rx(mode_rx),
    .end_rx(end_rx), .timeout_cycles(timeout_cycles),
    .synth_ready(synth_ready), .pkt_done(pkt_done), .crc_ok(crc_ok),
    .rx_crc(rx_crc), .go_pending(go_pending), .busy(busy), .pwr_en(pwr_en),
    .tx_en(tx_en), .rx_en(rx_en), .tx_start(tx_start), .send_ack(send_ack),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .ack_crc(ack_crc),
    .rx_irq(rx_irq), .done_irq(done_irq), .no_ack(no_ack)
  );

  // behavioural reference
  int ph = P_IDLE;
  int nph;
  int waited = 0;
  int lim;
  bit m_go = 0, m_mode = 0, m_noack = 0, m_txs = 0, m_rxi = 0;
  logic [CRC_W-1:0] m_crc = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_IDLE; m_go = 0; m_mode = 0; m_noack = 0;
      m_txs = 0; m_rxi = 0; m_crc = '0; waited = 0;
    end else begin
      nph = ph; m_txs = 0; m_rxi = 0;
      if (ph == P_IDLE && m_go) begin
        m_go = go_set; m_mode = mode_rx; m_noack = 0; nph = P_WARM;
      end else m_go = m_go | go_set;
      case (ph)
        P_WARM: if (synth_ready) begin
          nph = m_mode ? P_RXW : P_TXD;
          m_txs = !m_mode;
        end
        P_TXD: if (pkt_done) begin nph = P_ACKW; waited = 0; end
        P_ACKW: begin
          waited++;
          lim = (timeout_cycles == 0) ? 1 : int'(timeout_cycles);
          if (pkt_done && crc_ok) nph = P_END;
          else if (waited >= lim) begin nph = P_END; m_noack = 1; end
        end
        P_RXW: if (pkt_done && crc_ok) begin
          m_crc = rx_crc; nph = P_TXA; m_txs = 1; m_rxi = 1;
        end
        P_TXA: if (pkt_done) nph = P_END;
        P_END: nph = end_rx ? P_RXW : P_IDLE;
        default: ;
      endcase
      ph = nph;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R1", "go_pending", 32'(go_pending), 32'(m_go));
    chk("R2", "pwr_en", 32'(pwr_en), 32'(ph != P_IDLE));
    chk("R2", "busy", 32'(busy), 32'(ph != P_IDLE));
    chk("R3", "tx_en", 32'(tx_en), 32'(ph == P_TXD || ph == P_TXA));
    chk("R12", "rx_en", 32'(rx_en), 32'(ph == P_ACKW || ph == P_RXW));
    chk("R3", "tx_start", 32'(tx_start), 32'(m_txs));
    chk("R6", "send_ack", 32'(send_ack), 32'(ph == P_TXA));
    chk("R9", "buf_rd_en", 32'(buf_rd_en), 32'(ph == P_TXD));
    chk("R9", "buf_wr_en", 32'(buf_wr_en), 32'(ph == P_RXW));
    chk("R8", "ack_crc", 32'(ack_crc), 32'(m_crc));
    chk("R6", "rx_irq", 32'(rx_irq), 32'(m_rxi));
    chk("R10", "done_irq", 32'(done_irq), 32'(ph == P_END));
    chk("R11", "no_ack", 32'(no_ack), 32'(m_noack));
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic m);
    mode_rx = m; go_set = 1'b1; tick(); go_set = 1'b0;
  endtask

  task automatic pulse(input logic ok, input logic [CRC_W-1:0] c);
    pkt_done = 1'b1; crc_ok = ok; rx_crc = c; tick();
    pkt_done = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic wait_tx();  while (!tx_en) tick(); endtask
  task automatic wait_rx();  while (!rx_en) tick(); endtask
  task automatic wait_idle(); while (busy) tick(); endtask

  initial begin
    tick(3);
    chk("R1", "reset go_pending", 32'(go_pending), 0);
    chk("R8", "reset ack_crc", 32'(ack_crc), 0);
    rst_n = 1'b1;
    tick(2);

    // R2 R3 R4: transmit with acknowledgement, late synth lock
    go(1'b0);
    chk("R1", "go_pending set", 32'(go_pending), 1);
    tick(3);
    chk("R2", "no radio before lock", 32'(tx_en | rx_en), 0);
    synth_ready = 1'b1;
    wait_tx(); tick(2); pulse(1'b1, 16'h0);
    wait_rx(); tick(2); pulse(1'b1, 16'h5555);
    wait_idle();
    chk("R4", "no_ack after ack", 32'(no_ack), 0);

    // R5 R7: bad ack then timeout
    timeout_cycles = 16'd5;
    go(1'b0); wait_tx(); pulse(1'b1, 16'h0);
    wait_rx(); pulse(1'b0, 16'h7777);
    chk("R7", "bad ack keeps waiting", 32'(rx_en), 1);
    wait_idle();
    chk("R5", "no_ack after timeout", 32'(no_ack), 1);
    tick(4);
    chk("R11", "no_ack sticky", 32'(no_ack), 1);

    // R5 R11: ack in last allowed cycle
    timeout_cycles = 16'd4;
    go(1'b0); tick();
    chk("R11", "no_ack cleared at start", 32'(no_ack), 0);
    wait_tx(); pulse(1'b1, 16'h0);
    wait_rx(); tick(3); pulse(1'b1, 16'h0);
    wait_idle();
    chk("R5", "last-cycle ack wins", 32'(no_ack), 0);

    // R5: zero limit acts as one
    timeout_cycles = 16'd0;
    go(1'b0); wait_tx(); pulse(1'b1, 16'h0);
    wait_rx(); tick();
    chk("R5", "zero limit ends at once", 32'(done_irq), 1);
    wait_idle();
    chk("R5", "zero limit no_ack", 32'(no_ack), 1);

    // R6 R7 R8 R10: receive exchange, end state back to listening
    end_rx = 1'b1;
    go(1'b1); wait_rx();
    pulse(1'b0, 16'h1111);
    chk("R7", "bad packet still listening", 32'(rx_en), 1);
    chk("R7", "bad packet crc untouched", 32'(ack_crc), 0);
    pulse(1'b1, 16'hBEEF);
    chk("R6", "ack send", 32'(send_ack & tx_start & rx_irq), 1);
    chk("R8", "ack carries crc", 32'(ack_crc), 32'h0000BEEF);
    tick(); pulse(1'b1, 16'h0);
    tick(2);
    chk("R10", "returned to listening", 32'(rx_en & buf_wr_en), 1);
    pulse(1'b1, 16'h1234);
    chk("R8", "second crc", 32'(ack_crc), 32'h00001234);
    end_rx = 1'b0;
    pulse(1'b1, 16'h0);
    wait_idle();
    chk("R10", "idle enables off", 32'(pwr_en | tx_en | rx_en), 0);

    // R1: request queued while busy
    timeout_cycles = 16'd3;
    go(1'b0); tick();
    go(1'b0);
    chk("R1", "queued go", 32'(go_pending), 1);
    wait_tx(); pulse(1'b1, 16'h0);
    wait_idle(); tick();
    chk("R1", "queued go started", 32'(busy), 1);
    wait_tx(); pulse(1'b1, 16'h0);
    wait_idle(); tick(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule